// File: doc/BRIEF.md
# Strap-Selected SPI Register Access Port

This block is the slave side of a serial control port. A host reaches an internal register space of 8192 byte registers through it. At reset the block latches three strap inputs. The all-zero pattern turns the SPI engine on. Any other pattern leaves the SPI engine idle and reports a 7-bit I2C device address, for use by a separate I2C engine.

In SPI mode the host lowers chip select and clocks in a 16-bit instruction, MSB first. The instruction carries a direction bit, a length code and a 13-bit start address. One or more data bytes follow. After each byte the address steps down by one. Writes go out on a simple register bus as single-cycle strobes. Reads are fetched from that bus one byte ahead of the host.

The port configuration byte at address 0 is held inside the block and never appears on the register bus. This byte sets the data-pin mode: either one shared bidirectional data pin, or a separate output pin for read data. It also offers a soft reset. The block runs on a system clock that oversamples the serial pins.

Top module: `spi_reg_port`

## Requirements
- R1: The strap inputs are sampled only while `rst_n` is low. After reset is released, `spi_mode` and `i2c_addr` keep the latched values whatever the straps do.
- R2: A latched strap value of 0 sets `spi_mode`=1. Any other value sets `spi_mode`=0, and the SPI engine then issues no register-bus strobes and drives no data pin.
- R3: `i2c_addr` equals {4'b1001, strap[2], strap[1], strap[0]} as latched at reset.
- R4: The 16-bit instruction is sampled on rising SCLK edges, MSB first. Bit 15 is the direction (1 = read). Bits 14:13 are the length code. Bits 12:0 are the start address.
- R5: Length codes 00, 01 and 10 move 1, 2 and 3 bytes. Extra clocks after the last byte have no effect. Each byte after the first uses the previous address minus one, wrapping modulo 2^13.
- R6: Length code 11 streams bytes, with the address decrementing, until chip select rises.
- R7: Address 0 is the local configuration byte: bit 0 is soft reset, bit 1 selects the separate output pin. Reads and writes of address 0 never assert `reg_wr` or `reg_rd`. Reading address 0 returns {6'b0, unidir, 1'b0}.
- R8: Read data is launched MSB first on falling SCLK edges. The first data bit appears after the falling edge that follows the 16th instruction bit.
- R9: While `cs_n` is high, `sdio_oe` and `sdo_oe` are both 0.
- R10: After reset, read data leaves on `sdio_out` with `sdio_oe`. With configuration bit 1 set, read data leaves on `sdo` with `sdo_oe`. A change to this bit takes effect from the next transfer, and at most one output enable is high at a time.
- R11: A rising `cs_n` in the middle of a transfer aborts it. A partly received byte is never written, and the next transfer starts again with an instruction.
- R12: Writing a configuration byte with bit 0 set restores the configuration defaults (bidirectional mode), whatever the other bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial pins |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_m | input | 3 | Mode strap inputs |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data input (instruction and write data) |
| sdio_out | output | 1 | Read data on the shared pin |
| sdio_oe | output | 1 | Output enable of the shared pin |
| sdo | output | 1 | Read data on the separate output pin |
| sdo_oe | output | 1 | Output enable of the separate output pin |
| spi_mode | output | 1 | 1 when the straps selected SPI |
| i2c_addr | output | 7 | Device address derived from the straps |
| reg_addr | output | 13 | Register-bus address |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle after `reg_rd` |

## Verification
The bench aims at the address-0 crossing inside a stream and at the length limit. A design that leaked the configuration byte onto the bus, or that kept writing past the byte count, would log extra or wrong register writes. It aborts a write part-way through a byte and aborts a read mid-byte: a faulty abort would commit a fragment or leave a pin driven after chip select rises. It changes the pin mode and then uses soft reset, which exposes a mode switch applied too early or a soft reset that leaves the mode bit set. It reapplies reset with every non-zero strap pattern, then moves the straps without reset, which catches an address that tracks the live straps.

// File: rtl/spi_port_pkg.sv
// Shared types and constants for the strap-selected SPI register port.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spi_port_pkg;
    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } xfer_phase_e;

    localparam int CFG_SOFT_RST_BIT = 0;
    localparam int CFG_UNIDIR_BIT   = 1;
    localparam logic [1:0] LEN_STREAM = 2'b11;
endpackage

// File: rtl/spi_strap_latch.sv
// Latches the mode straps during reset and derives protocol select and
// the I2C device address. Assumes straps are stable while rst_n is low.
module spi_strap_latch #(
    parameter int STRAP_W    = 3,
    parameter int DEV_ADDR_W = 7,
    parameter logic [DEV_ADDR_W-1:0] ADDR_BASE = 7'b1001000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STRAP_W-1:0]    strap_m,
    output logic                  spi_en,
    output logic [DEV_ADDR_W-1:0] dev_addr
);
    localparam int HI_W = DEV_ADDR_W - STRAP_W;

    logic [STRAP_W-1:0] strap_q;

    // Capture straps only while reset is held; hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_m;
        end
    end

    // Decode protocol and device address from the held strap value.
    always_comb begin
        spi_en   = (strap_q == '0);
        dev_addr = {ADDR_BASE[DEV_ADDR_W-1 -: HI_W], strap_q};
    end

    // R1: the latched straps never move outside reset.
    p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/spi_pin_sync.sv
// Brings sclk, cs_n and the data input into the system clock domain and
// produces single-cycle SCLK edge pulses. Assumes clk is at least about
// eight times faster than SCLK.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic sdi_s
);
    localparam int PIN_W = 3;
    localparam logic [PIN_W-1:0] PIN_IDLE = 3'b010; // {sclk, cs_n, sdi}

    logic [PIN_W-1:0] pipe [STAGES];
    logic             sclk_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= PIN_IDLE;
                    else        pipe[g] <= {sclk, cs_n, sdi};
                end
            end else begin : g_next
                // Later stages resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= PIN_IDLE;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    // Remember the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= pipe[STAGES-1][2];
    end

    // Edge pulses and qualified pin levels.
    always_comb begin
        sclk_rise = pipe[STAGES-1][2] & ~sclk_prev;
        sclk_fall = ~pipe[STAGES-1][2] & sclk_prev;
        cs_act    = ~pipe[STAGES-1][1];
        sdi_s     = pipe[STAGES-1][0];
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
// SPI framing engine: instruction decode, byte assembly, address
// decrement, register-bus strobes, read prefetch, local configuration
// byte and read-data launch. Assumes edge pulses from spi_pin_sync and a
// register bus whose read data is valid the cycle after reg_rd.
module spi_frame_ctrl
    import spi_port_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_en,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              sdi_s,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              out_bit,
    output logic              drive_en,
    output logic              uni_xfer
);
    localparam int INSTR_W = ADDR_W + 3;
    localparam int CNT_W   = $clog2(INSTR_W);
    localparam int RW_BIT  = INSTR_W - 1;
    localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);

    xfer_phase_e       phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [INSTR_W-1:0] instr_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] tx_sr;
    logic [ADDR_W-1:0] addr_q;
    logic              is_read;
    logic [1:0]        len_code;
    logic [1:0]        byte_idx;
    logic              rd_pend;
    logic              cfg_unidir;

    logic              active;
    logic [INSTR_W-1:0] instr_nx;
    logic [DATA_W-1:0] rx_nx;
    logic              hdr_end;
    logic              byte_end;
    logic              last_byte;
    logic              fetch_en;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] cfg_byte;
    logic              cfg_hit_wr;

    // Next-state terms shared by the sequencing processes.
    always_comb begin
        active     = spi_en & cs_act;
        instr_nx   = {instr_sr[INSTR_W-2:0], sdi_s};
        rx_nx      = {rx_sr[DATA_W-2:0], sdi_s};
        hdr_end    = active & sclk_rise & (phase == PH_INSTR) & (bit_cnt == INSTR_LAST);
        byte_end   = active & sclk_rise & (phase == PH_DATA) & (bit_cnt == DATA_LAST);
        last_byte  = (len_code != LEN_STREAM) && (byte_idx == len_code);
        fetch_en   = (hdr_end & instr_nx[RW_BIT]) | (byte_end & is_read & ~last_byte);
        fetch_addr = hdr_end ? instr_nx[ADDR_W-1:0] : addr_q - 1'b1;
        cfg_byte   = '0;
        cfg_byte[CFG_UNIDIR_BIT] = cfg_unidir;
        cfg_hit_wr = byte_end & ~is_read & (addr_q == '0);
    end

    // Phase, bit counter, shift registers and address sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_INSTR;
            bit_cnt  <= '0;
            instr_sr <= '0;
            rx_sr    <= '0;
            addr_q   <= '0;
            is_read  <= 1'b0;
            len_code <= 2'b00;
            byte_idx <= 2'b00;
        end else if (!active) begin
            phase    <= PH_INSTR;
            bit_cnt  <= '0;
            byte_idx <= 2'b00;
        end else if (sclk_rise) begin
            case (phase)
                PH_INSTR: begin
                    instr_sr <= instr_nx;
                    if (bit_cnt == INSTR_LAST) begin
                        is_read  <= instr_nx[RW_BIT];
                        len_code <= instr_nx[RW_BIT-1 -: 2];
                        addr_q   <= instr_nx[ADDR_W-1:0];
                        byte_idx <= 2'b00;
                        bit_cnt  <= '0;
                        phase    <= PH_DATA;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    rx_sr <= rx_nx;
                    if (bit_cnt == DATA_LAST) begin
                        bit_cnt <= '0;
                        addr_q  <= addr_q - 1'b1;
                        if (byte_idx != 2'b11) byte_idx <= byte_idx + 1'b1;
                        if (last_byte) phase <= PH_DONE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

    // Register-bus strobes: write commit and read fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            rd_pend   <= 1'b0;
        end else begin
            reg_wr  <= 1'b0;
            reg_rd  <= 1'b0;
            rd_pend <= reg_rd;
            if (byte_end && !is_read && addr_q != '0) begin
                reg_wr    <= 1'b1;
                reg_addr  <= addr_q;
                reg_wdata <= rx_nx;
            end else if (fetch_en && fetch_addr != '0) begin
                reg_rd   <= 1'b1;
                reg_addr <= fetch_addr;
            end
        end
    end

    // Local configuration byte with soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_unidir <= 1'b0;
        end else if (cfg_hit_wr) begin
            if (rx_nx[CFG_SOFT_RST_BIT]) cfg_unidir <= 1'b0;
            else                         cfg_unidir <= rx_nx[CFG_UNIDIR_BIT];
        end
    end

    // Read data path: load, launch on falling SCLK, drive enable, pin mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            out_bit  <= 1'b0;
            drive_en <= 1'b0;
            uni_xfer <= 1'b0;
        end else begin
            if (!cs_act) uni_xfer <= cfg_unidir;
            if (!active) begin
                drive_en <= 1'b0;
            end else if (fetch_en && fetch_addr == '0) begin
                tx_sr <= cfg_byte;
            end else if (rd_pend) begin
                tx_sr <= reg_rdata;
            end else if (sclk_fall && phase == PH_DATA && is_read) begin
                out_bit  <= tx_sr[DATA_W-1];
                tx_sr    <= {tx_sr[DATA_W-2:0], 1'b0};
                drive_en <= 1'b1;
            end
        end
    end

    // R7: the configuration byte never reaches the register bus.
    p_cfg_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> (reg_addr != '0));
    // R11: a write strobe only follows a rising SCLK inside a selected transfer.
    p_wr_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ($past(sclk_rise) && $past(cs_act)));
    // R5: each fetch is a single-cycle strobe.
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    // R2: with the SPI engine off nothing reaches the bus or the pins.
    p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> (!reg_wr && !reg_rd && !drive_en));
    // R10: the pin mode is frozen while a transfer is selected.
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act)) |-> $stable(uni_xfer));
endmodule

// File: rtl/spi_reg_port.sv
// Top of the strap-selected SPI register port. Combines strap latch, pin
// synchronizer and framing engine and gates the pin output enables with
// chip select. Assumes clk oversamples SCLK by roughly eight or more.
module spi_reg_port #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int STRAP_W    = 3,
    parameter int DEV_ADDR_W = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STRAP_W-1:0]    strap_m,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  sdio_in,
    output logic                  sdio_out,
    output logic                  sdio_oe,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic                  spi_mode,
    output logic [DEV_ADDR_W-1:0] i2c_addr,
    output logic [ADDR_W-1:0]     reg_addr,
    output logic                  reg_wr,
    output logic [DATA_W-1:0]     reg_wdata,
    output logic                  reg_rd,
    input  logic [DATA_W-1:0]     reg_rdata
);
    logic spi_en;
    logic sclk_rise;
    logic sclk_fall;
    logic cs_act;
    logic sdi_s;
    logic out_bit;
    logic drive_en;
    logic uni_xfer;

    spi_strap_latch #(
        .STRAP_W   (STRAP_W),
        .DEV_ADDR_W(DEV_ADDR_W)
    ) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_m (strap_m),
        .spi_en  (spi_en),
        .dev_addr(i2c_addr)
    );

    spi_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdi      (sdio_in),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cs_act   (cs_act),
        .sdi_s    (sdi_s)
    );

    spi_frame_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_en   (spi_en),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cs_act   (cs_act),
        .sdi_s    (sdi_s),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rd   (reg_rd),
        .reg_rdata(reg_rdata),
        .out_bit  (out_bit),
        .drive_en (drive_en),
        .uni_xfer (uni_xfer)
    );

    // Pin drivers: raw chip select releases both pins at once.
    always_comb begin
        spi_mode = spi_en;
        sdio_out = out_bit;
        sdo      = out_bit;
        sdio_oe  = ~cs_n & drive_en & ~uni_xfer;
        sdo_oe   = ~cs_n & drive_en & uni_xfer;
    end

    // R9: chip select high means both pins are released.
    p_hiz_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sdio_oe && !sdo_oe));
    // R10: never both pins driven.
    p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdio_oe, sdo_oe}));
    // R9: the framing engine drops its drive once deselect is seen.
    p_drop_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !drive_en);
endmodule

// File: tb/sim_spi_reg_port.sv
module sim_spi_reg_port;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap_m = 3'b000;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdio_in = 1'b0;
    logic        sdio_out, sdio_oe, sdo, sdo_oe, spi_mode;
    logic [6:0]  i2c_addr;
    logic [12:0] reg_addr;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;

    int n_chk = 0;
    int n_fail = 0;

    spi_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .strap_m(strap_m), .sclk(sclk), .cs_n(cs_n),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
        .sdo_oe(sdo_oe), .spi_mode(spi_mode), .i2c_addr(i2c_addr),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] init_byte(input int i);
        return 8'(i * 37 + 8'h5A);
    endfunction

    // Register-file slave model with write log.
    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    logic [12:0] wlog_a [512];
    logic [7:0]  wlog_d [512];
    int wr_n = 0;
    int rd_n = 0;
    bit seeded = 1'b0;
    always @(posedge clk) begin
        if (!seeded) begin
            for (int i = 0; i < 256; i++) mem[i] = init_byte(i);
            seeded = 1'b1;
        end else begin
            if (reg_wr) begin
                mem[reg_addr[7:0]] = reg_wdata;
                if (wr_n < 512) begin
                    wlog_a[wr_n] = reg_addr;
                    wlog_d[wr_n] = reg_wdata;
                end
                wr_n = wr_n + 1;
            end
            if (reg_rd) begin
                reg_rdata <= mem[reg_addr[7:0]];
                rd_n = rd_n + 1;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic half_period();
        repeat (HALF) @(negedge clk);
    endtask

    logic [7:0] tx_buf [8];
    logic [7:0] rxa [8];
    logic [7:0] rxb [8];
    logic       oea [8];
    logic       oeb [8];
    logic       oe_before, oe_after;

    task automatic spi_xfer(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                            input int nbits);
        logic [15:0] hdr;
        hdr = {rd, len, addr};
        cs_n = 1'b0;
        half_period();
        for (int i = 0; i < 16; i++) begin
            sdio_in = hdr[15-i];
            half_period();
            sclk = 1'b1;
            half_period();
            sclk = 1'b0;
        end
        for (int i = 0; i < nbits; i++) begin
            sdio_in = tx_buf[i/8][7 - i%8];
            half_period();
            rxa[i/8][7 - i%8] = sdio_out;
            rxb[i/8][7 - i%8] = sdo;
            if (i % 8 == 0) begin
                oea[i/8] = sdio_oe;
                oeb[i/8] = sdo_oe;
            end
            sclk = 1'b1;
            half_period();
            sclk = 1'b0;
        end
        half_period();
        oe_before = sdio_oe | sdo_oe;
        cs_n = 1'b1;
        #1;
        oe_after = sdio_oe | sdo_oe;
        repeat (4) half_period();
    endtask

    task automatic do_reset(input logic [2:0] s);
        @(negedge clk);
        strap_m = s;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int base;
        int rbase;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) ref_mem[i] = init_byte(i);
        do_reset(3'b000);

        // Reset state (R1, R2, R9, R10).
        check(spi_mode == 1'b1, "R2 spi_mode after zero straps", spi_mode, 1);
        check(!sdio_oe && !sdo_oe, "R9 pins released at reset", {sdio_oe, sdo_oe}, 0);

        // Single write (R4).
        base = wr_n;
        tx_buf[0] = 8'h3C;
        spi_xfer(1'b0, 2'b00, 13'h0A5, 8);
        ref_mem[8'hA5] = 8'h3C;
        check(wr_n - base == 1, "R4 single write count", wr_n - base, 1);
        check(wlog_a[base] == 13'h0A5 && wlog_d[base] == 8'h3C, "R4 single write addr/data",
              {wlog_a[base], wlog_d[base]}, {13'h0A5, 8'h3C});

        // Single read on shared pin (R8, R10).
        rbase = rd_n;
        spi_xfer(1'b1, 2'b00, 13'h0A5, 8);
        check(rxa[0] == 8'h3C, "R8 read data MSB first", rxa[0], 8'h3C);
        check(oea[0] && !oeb[0], "R10 default bidirectional pin", {oea[0], oeb[0]}, 2'b10);
        check(rd_n - rbase == 1, "R4 one fetch per byte", rd_n - rbase, 1);
        check(!oe_after, "R9 release after read", oe_after, 0);

        // Three-byte write with decrement (R5).
        base = wr_n;
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
        spi_xfer(1'b0, 2'b10, 13'h012, 24);
        ref_mem[8'h12] = 8'h11; ref_mem[8'h11] = 8'h22; ref_mem[8'h10] = 8'h33;
        check(wr_n - base == 3, "R5 three-byte count", wr_n - base, 3);
        check(wlog_a[base+2] == 13'h010 && wlog_d[base+2] == 8'h33, "R5 third byte address",
              wlog_a[base+2], 13'h010);

        // Two-byte read (R5, R8).
        spi_xfer(1'b1, 2'b01, 13'h011, 16);
        check(rxa[0] == 8'h22 && rxa[1] == 8'h33, "R5 two-byte read", {rxa[0], rxa[1]}, 16'h2233);

        // Length limit: extra byte ignored (R5).
        base = wr_n;
        tx_buf[0] = 8'h99; tx_buf[1] = 8'hAA;
        spi_xfer(1'b0, 2'b00, 13'h040, 16);
        ref_mem[8'h40] = 8'h99;
        check(wr_n - base == 1, "R5 clocks past length ignored", wr_n - base, 1);
        spi_xfer(1'b1, 2'b00, 13'h03F, 8);
        check(rxa[0] == ref_mem[8'h3F], "R5 neighbour untouched", rxa[0], ref_mem[8'h3F]);

        // Streaming across address 0 with wrap (R6, R7).
        base = wr_n;
        rbase = rd_n;
        tx_buf[0] = 8'h61; tx_buf[1] = 8'h62; tx_buf[2] = 8'h00; tx_buf[3] = 8'h64;
        spi_xfer(1'b0, 2'b11, 13'h002, 32);
        ref_mem[8'h02] = 8'h61; ref_mem[8'h01] = 8'h62; ref_mem[8'hFF] = 8'h64;
        check(wr_n - base == 3, "R7 config byte kept off bus in stream", wr_n - base, 3);
        check(wlog_a[base+2] == 13'h1FFF && wlog_d[base+2] == 8'h64, "R6 stream wrap address",
              wlog_a[base+2], 13'h1FFF);
        spi_xfer(1'b1, 2'b00, 13'h000, 8);
        check(rxa[0] == 8'h00 && rd_n == rbase, "R7 config read local default",
              {rd_n - rbase, rxa[0]}, 0);

        // Aborted write leaves nothing (R11), next transfer framed afresh.
        base = wr_n;
        tx_buf[0] = 8'hF0;
        spi_xfer(1'b0, 2'b00, 13'h033, 5);
        check(wr_n == base, "R11 partial byte not written", wr_n - base, 0);
        tx_buf[0] = 8'h77;
        spi_xfer(1'b0, 2'b00, 13'h033, 8);
        ref_mem[8'h33] = 8'h77;
        check(wr_n - base == 1 && wlog_a[base] == 13'h033 && wlog_d[base] == 8'h77,
              "R11 framing restarts after abort", {wlog_a[base], wlog_d[base]}, {13'h033, 8'h77});

        // Mid-read deselect releases pin (R9, R11).
        spi_xfer(1'b1, 2'b00, 13'h0A5, 12);
        check(oe_before && !oe_after, "R9 release on mid-read deselect",
              {oe_before, oe_after}, 2'b10);

        // Unidirectional mode (R10).
        tx_buf[0] = 8'h02;
        spi_xfer(1'b0, 2'b00, 13'h000, 8);
        spi_xfer(1'b1, 2'b00, 13'h000, 8);
        check(rxb[0] == 8'h02 && oeb[0] && !oea[0], "R10 config on separate pin",
              {oeb[0], oea[0], rxb[0]}, {2'b10, 8'h02});
        spi_xfer(1'b1, 2'b00, 13'h0A5, 8);
        check(rxb[0] == 8'h3C, "R10 data on separate pin", rxb[0], 8'h3C);

        // Soft reset wins over the mode bit (R12).
        tx_buf[0] = 8'h03;
        spi_xfer(1'b0, 2'b00, 13'h000, 8);
        spi_xfer(1'b1, 2'b00, 13'h000, 8);
        check(rxa[0] == 8'h00 && oea[0] && !oeb[0], "R12 soft reset restores bidirectional",
              {oea[0], oeb[0], rxa[0]}, {2'b10, 8'h00});

        // Random single and multi-byte traffic (R4, R5, R8).
        for (int k = 0; k < 24; k++) begin
            int n;
            logic rd;
            logic [12:0] a;
            n  = int'($urandom % 3) + 1;
            rd = 1'($urandom % 2);
            a  = 13'(16 + ($urandom % 240));
            if (rd) begin
                spi_xfer(1'b1, 2'(n - 1), a, n * 8);
                for (int j = 0; j < n; j++)
                    check(rxa[j] == ref_mem[8'(a - 13'(j))], "R8 random read byte",
                          rxa[j], ref_mem[8'(a - 13'(j))]);
            end else begin
                base = wr_n;
                for (int j = 0; j < n; j++) tx_buf[j] = 8'($urandom);
                spi_xfer(1'b0, 2'(n - 1), a, n * 8);
                check(wr_n - base == n, "R5 random write count", wr_n - base, n);
                for (int j = 0; j < n; j++) begin
                    ref_mem[8'(a - 13'(j))] = tx_buf[j];
                    check(wlog_a[base+j] == a - 13'(j) && wlog_d[base+j] == tx_buf[j],
                          "R4 random write entry", wlog_a[base+j], a - 13'(j));
                end
            end
        end

        // Strap patterns selecting I2C (R2, R3).
        for (int p = 1; p < 8; p++) begin
            do_reset(3'(p));
            check(spi_mode == 1'b0, "R2 non-zero straps select I2C", spi_mode, 0);
            check(i2c_addr == {4'b1001, 3'(p)}, "R3 device address", i2c_addr, {4'b1001, 3'(p)});
        end
        do_reset(3'b101);
        strap_m = 3'b010;
        repeat (5) @(negedge clk);
        check(i2c_addr == 7'b1001101 && spi_mode == 1'b0, "R1 straps ignored after reset",
              i2c_addr, 7'b1001101);
        base = wr_n;
        tx_buf[0] = 8'h55;
        spi_xfer(1'b0, 2'b00, 13'h050, 8);
        spi_xfer(1'b1, 2'b00, 13'h050, 8);
        check(wr_n == base && !oea[0] && !oeb[0], "R2 SPI engine idle in I2C mode",
              {wr_n - base, oea[0], oeb[0]}, 0);
        do_reset(3'b000);
        check(spi_mode == 1'b1, "R1 new straps taken at next reset", spi_mode, 1);

        summary();
        $finish;
    end
endmodule